// File: doc/BRIEF.md
# Programmable Tone Generator with Reference-Clock Gating

This block produces a square wave on a single pin for driving a buzzer. A 16-bit divide value N sets how many counting ticks each output level lasts: N+1 ticks high, then N+1 ticks low. The ticks come either from every cycle of the system clock or from each rising edge of a slow reference clock. An optional modulation mode gates the tone with the reference clock, which gives a lower-volume output.

Software programs the block through a simple byte-wide write port. The low byte of N goes into a holding buffer. Writing the high byte commits both bytes to the divider at the same moment, so the counter never sees a half-written value. A committed value takes effect at the next terminal count, which means the half-period already in progress always finishes at its old length. When the committed value is zero the generator is idle and the pin stays high. Clearing the enable bit freezes the pin at its present level.

The controller is a three-state machine:
- S_IDLE: the divide value is zero and the output is forced high.
- S_RUN: the generator is counting ticks and toggling the output.
- S_HOLD: the generator is disabled and the counter and output are frozen.

The transitions are:
- S_IDLE to S_RUN: a nonzero value is committed while enabled.
- S_IDLE to S_HOLD: a nonzero value is committed while disabled.
- S_RUN to S_HOLD: the enable bit is cleared.
- S_RUN to S_IDLE: a terminal count is reached while the committed value is zero.
- S_HOLD to S_RUN: the enable bit is set.
- S_HOLD to S_IDLE: a zero value is committed.

Top module: `tone_gen`

## Requirements
- R1: With committed value N (1..65535), while enabled, each output level lasts exactly N+1 counting ticks, so the output period is 2(N+1) ticks.
- R2: The extremes of the range hold: N=1 gives levels of 2 ticks and N=0xFFFF gives levels of 65536 ticks.
- R3: After reset, and whenever the committed value is zero, the output is high and does not toggle.
- R4: Write-port map: address 1 loads the low-byte buffer only; address 2 commits {data, low buffer} as the new divide value. A write to address 1 alone leaves the running period unchanged.
- R5: Address 0 is the control byte. Bit 0 is enable. Clearing bit 0 freezes the output at its current level. Setting it again resumes toggling with full N+1 tick levels.
- R6: Control bit 1 selects the counting tick: 0 counts every system-clock cycle, 1 counts each rising edge of the synchronized reference clock.
- R7: Control bit 2 enables modulation. While it is set and the generator runs, the output is the tone ANDed with the synchronized reference clock. The output is therefore low whenever the reference is low.
- R8: A value committed in the middle of a half-period does not shorten or lengthen that half-period. The new length applies from the next terminal count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (0 control, 1 low byte, 2 high byte and commit) |
| wr_data | input | 8 | Write data |
| ref_clk | input | 1 | Slow reference clock, sampled through a synchronizer |
| tone_out | output | 1 | Buzzer square-wave output |

## Verification
The assertions check several properties on every cycle:
- the output is high in the idle state;
- the output is frozen while held;
- the tone changes only at a terminal count;
- the counter steps down by exactly one per tick;
- the output is low under modulation whenever the reference is low;
- a low-byte write never alters the committed value.

Other behaviour only the bench scenarios can show: the exact half-period lengths for random and extreme divide values, the tick counting in reference-clock mode, and that a mid-period commit leaves the current half-period intact before the new length applies.

// File: rtl/tg_pkg.sv
package tg_pkg;
    localparam int ADDR_W    = 2;
    localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_LO   = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_HI   = 2'd2;
    localparam int CTRL_EN  = 0;
    localparam int CTRL_SEL = 1;
    localparam int CTRL_MOD = 2;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_RUN  = 2'd1,
        S_HOLD = 2'd2
    } tg_state_e;
endpackage

// File: rtl/tg_regs.sv
module tg_regs
    import tg_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int DIV_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic              en_o,
    output logic              sel_o,
    output logic              mod_o,
    output logic [DIV_W-1:0]  div_o
);
    logic [BYTE_W-1:0] ctrl_q;
    logic [BYTE_W-1:0] lo_buf_q;
    logic [DIV_W-1:0]  div_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            lo_buf_q <= '0;
            div_q    <= '0;
        end else if (wr_en) begin
            unique case (wr_addr)
                ADDR_CTRL: ctrl_q   <= wr_data;
                ADDR_LO:   lo_buf_q <= wr_data;
                ADDR_HI:   div_q    <= {wr_data, lo_buf_q};
                default:   ;
            endcase
        end
    end

    assign en_o  = ctrl_q[CTRL_EN];
    assign sel_o = ctrl_q[CTRL_SEL];
    assign mod_o = ctrl_q[CTRL_MOD];
    assign div_o = div_q;

    // R4: buffering the low byte never disturbs the committed value
    a_r4_lo_no_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_LO) |=> $stable(div_q));
endmodule

// File: rtl/tg_tick.sv
module tg_tick #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_in,
    input  logic sel,
    output logic ref_lvl_o,
    output logic tick_o
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    generate
        for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[0] <= 1'b0;
                    else        sync_q[0] <= ref_in;
                end
            end else begin : g_rest
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[i] <= 1'b0;
                    else        sync_q[i] <= sync_q[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[SYNC_STAGES-1];
    end

    assign ref_lvl_o = sync_q[SYNC_STAGES-1];
    assign tick_o    = sel ? (ref_lvl_o & ~prev_q) : 1'b1;

    // R6: in reference mode a tick is never issued on two consecutive cycles
    a_r6_ref_tick_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && tick_o) |=> (!tick_o || !sel));
endmodule

// File: rtl/tg_core.sv
module tg_core
    import tg_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             mod,
    input  logic             tick,
    input  logic             ref_lvl,
    input  logic [DIV_W-1:0] div,
    output logic             tone_o
);
    tg_state_e        state_q, state_d;
    logic [DIV_W-1:0] cnt_q;
    logic             tone_q;
    logic             out_q;
    logic             terminal;
    logic             tone_n;

    assign terminal = en && tick && (cnt_q == '0);
    assign tone_n   = terminal ? ~tone_q : tone_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (div != '0) state_d = en ? S_RUN : S_HOLD;
            S_RUN: begin
                if (!en)                        state_d = S_HOLD;
                else if (terminal && div == '0) state_d = S_IDLE;
            end
            S_HOLD: begin
                if (div == '0) state_d = S_IDLE;
                else if (en)   state_d = S_RUN;
            end
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            tone_q <= 1'b1;
            out_q  <= 1'b1;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    cnt_q  <= div;
                    tone_q <= 1'b1;
                    out_q  <= 1'b1;
                end
                S_RUN: begin
                    if (en) begin
                        if (terminal)  cnt_q <= div;
                        else if (tick) cnt_q <= cnt_q - 1'b1;
                        tone_q <= tone_n;
                        out_q  <= mod ? (tone_n & ref_lvl) : tone_n;
                    end
                end
                S_HOLD: ;
                default: ;
            endcase
        end
    end

    assign tone_o = out_q;

    // R3: idle forces a high output
    a_r3_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE) |=> out_q);
    // R5: output frozen while disabled
    a_r5_hold_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_HOLD || (state_q == S_RUN && !en)) |=> out_q == $past(out_q));
    // R1: counter steps by one per tick
    a_r1_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RUN && en && tick && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
    // R8: tone only changes at a terminal count
    a_r8_toggle_terminal: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RUN && !terminal) |=> tone_q == $past(tone_q));
    // R7: modulation gates output low while reference is low
    a_r7_mod_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RUN && en && mod && !ref_lvl) |=> !out_q);
endmodule

// File: rtl/tone_gen.sv
module tone_gen
    import tg_pkg::*;
#(
    parameter int BYTE_W      = 8,
    parameter int SYNC_STAGES = 2,
    localparam int DIV_W      = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              ref_clk,
    output logic              tone_out
);
    logic             en, sel, mod, tick, ref_lvl;
    logic [DIV_W-1:0] div;

    tg_regs #(.BYTE_W(BYTE_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .en_o(en), .sel_o(sel), .mod_o(mod), .div_o(div)
    );

    tg_tick #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
        .clk(clk), .rst_n(rst_n), .ref_in(ref_clk), .sel(sel),
        .ref_lvl_o(ref_lvl), .tick_o(tick)
    );

    tg_core #(.DIV_W(DIV_W)) u_core (
        .clk(clk), .rst_n(rst_n), .en(en), .mod(mod), .tick(tick),
        .ref_lvl(ref_lvl), .div(div), .tone_o(tone_out)
    );
endmodule

// File: tb/tone_gen_test.sv
module tone_gen_test;
    localparam int CLK_PERIOD = 10;
    localparam int REF_HALF   = 3;
    localparam int LIMIT      = 200000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       ref_run = 1'b0;
    logic       ref_static = 1'b0;
    logic       ref_osc = 1'b0;
    logic       ref_clk;
    logic       tone_out;
    int         errors = 0;
    int         checks = 0;
    int         rc = 0;

    assign ref_clk = ref_run ? ref_osc : ref_static;

    tone_gen uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .ref_clk(ref_clk), .tone_out(tone_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        if (ref_run) begin
            rc = rc + 1;
            if (rc >= REF_HALF) begin
                rc = 0;
                ref_osc = ~ref_osc;
            end
        end
    end

    function automatic int exp_level(int n, int ticks_per);
        return (n + 1) * ticks_per;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_div(int n);
        wr(2'd1, n[7:0]);
        wr(2'd2, n[15:8]);
    endtask

    task automatic run_len(output int len);
        logic v;
        int c;
        @(negedge clk);
        v = tone_out; c = 0;
        while (tone_out == v && c < LIMIT) begin @(negedge clk); c++; end
        v = tone_out; len = 0;
        while (tone_out == v && len < LIMIT) begin @(negedge clk); len++; end
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        int len;
        int n;
        logic v;
        bit ok;
        void'($urandom(32'h5eed));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(tone_out == 1'b1, "R3 reset high", tone_out, 1);

        // R6 counting on system clock, enabled
        wr(2'd0, 8'h01);
        // R1 random divide values
        for (int i = 0; i < 6; i++) begin
            n = 1 + int'($urandom_range(40));
            set_div(n);
            run_len(len); run_len(len);
            check(len == exp_level(n, 1), "R1 level length", len, exp_level(n, 1));
            run_len(len);
            check(len == exp_level(n, 1), "R1 level length", len, exp_level(n, 1));
        end

        // R2 minimum
        set_div(1);
        run_len(len); run_len(len);
        check(len == 2, "R2 minimum level", len, 2);

        // R4 low-byte write alone leaves the period unchanged
        set_div(7);
        run_len(len); run_len(len);
        wr(2'd1, 8'h02);
        run_len(len); run_len(len);
        check(len == 8, "R4 low write no effect", len, 8);
        wr(2'd2, 8'h00);
        run_len(len); run_len(len);
        check(len == 3, "R4 high write commits", len, 3);

        // R8 mid-period commit keeps current half-period
        set_div(9);
        run_len(len);
        @(negedge clk); v = tone_out;
        while (tone_out == v) @(negedge clk);
        v = tone_out;
        wr_en = 1'b1; wr_addr = 2'd1; wr_data = 8'd3;
        @(negedge clk); len = 1;
        wr_addr = 2'd2; wr_data = 8'd0;
        @(negedge clk); len++;
        wr_en = 1'b0;
        while (tone_out == v && len < LIMIT) begin @(negedge clk); len++; end
        check(len == 10, "R8 current half kept", len, 10);
        v = tone_out; len = 0;
        while (tone_out == v && len < LIMIT) begin @(negedge clk); len++; end
        check(len == 4, "R8 new length next", len, 4);

        // R5 freeze on enable clear
        set_div(20);
        run_len(len);
        wr(2'd0, 8'h00);
        v = tone_out; ok = 1;
        repeat (60) begin @(negedge clk); if (tone_out != v) ok = 0; end
        check(ok, "R5 frozen output", tone_out, v);
        wr(2'd0, 8'h01);
        run_len(len);
        check(len == 21, "R5 resumes", len, 21);

        // R7 modulation with reference low then high
        set_div(5);
        ref_static = 1'b0;
        wr(2'd0, 8'h05);
        repeat (4) @(negedge clk);
        ok = 1;
        repeat (40) begin @(negedge clk); if (tone_out) ok = 0; end
        check(ok, "R7 gated low", tone_out, 0);
        ref_static = 1'b1;
        run_len(len); run_len(len);
        check(len == 6, "R7 passes tone when ref high", len, 6);

        // R6 reference-edge counting
        wr(2'd0, 8'h03);
        ref_run = 1'b1;
        set_div(4);
        run_len(len); run_len(len);
        check(len == exp_level(4, 2 * REF_HALF), "R6 reference ticks", len, exp_level(4, 2 * REF_HALF));
        ref_run = 1'b0;
        wr(2'd0, 8'h01);

        // R3 zero value idles high
        set_div(0);
        repeat (40) @(negedge clk);
        ok = 1;
        repeat (100) begin @(negedge clk); if (!tone_out) ok = 0; end
        check(ok, "R3 zero idles high", tone_out, 1);

        // R2 maximum
        set_div(16'hFFFF);
        run_len(len);
        check(len == 65536, "R2 maximum level", len, 65536);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule